// File: doc/BRIEF.md
# Scissor Clip Register Bank

This block stores the clipping rectangle of a 2D drawing engine. It holds the destination scissor, which has top, left, bottom and right bounds. It holds the source scissor, which has bottom and right bounds. It also holds a default bottom-right corner. Software updates these values through a small synchronous register port. Each bound has a register of its own. Each bound can also be set through a packed pair register that fills two bounds in one write. The current destination and source bounds are driven straight out of the block, so that a later clip stage can use them without going through the register port.

A second write input carries the drawing engine's master control word. Two bits of that word decide where the scissors come from. When the source clip bit is clear, the source scissor is reloaded from the defaults. When the destination clip bit is clear, the destination scissor is reset to the full default rectangle, with its origin at zero. When a clip bit is set, the bounds written by software are kept.

Top module: `scissor_bank`

## Requirements
- R1: While reset is high, and right after it, all eight bounds, `reg_rdata` and `rd_err` are zero.
- R2: The individual registers are destination top 0x00, left 0x01, bottom 0x02 and right 0x03, then source bottom 0x04 and source right 0x05. A write stores `reg_wdata[13:0]`. A read returns that 14-bit value zero-extended to 32 bits.
- R3: Each pair register takes its low field from `reg_wdata[13:0]` and its high field from `reg_wdata[29:16]`. The pairs are: destination top-left at 0x08 (left low, top high), destination bottom-right at 0x09 (right low, bottom high), source bottom-right at 0x0A (right low, bottom high) and default bottom-right at 0x0B (right low, bottom high).
- R4: A read from 0x08, 0x09 or 0x0A returns zero. It sets `rd_err` high for exactly the one cycle in which that read data is presented.
- R5: A read from 0x0B returns the default bottom in bits [29:16] and the default right in bits [13:0], with every other bit zero. It does not raise `rd_err`.
- R6: A master control write with bit 2 clear loads source right from default right and source bottom from default bottom.
- R7: A master control write with bit 3 clear sets destination top and left to zero, and loads destination right and bottom from the defaults.
- R8: A master control write leaves the source bounds unchanged when bit 2 is set, and leaves the destination bounds unchanged when bit 3 is set.
- R9: A read from any unmapped address returns zero, does not raise `rd_err`, and changes no bound.
- R10: If a register write and a master control reload hit the same bound in the same cycle, the reload wins. The reload uses the default values held before that clock edge.
- R11: A write updates the bound outputs at its own clock edge. A read issued in the next cycle returns the new value. Read data appears one cycle after the read strobe and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| rd_err | output | 1 | One-cycle flag: a write-only pair was read |
| mc_we | input | 1 | Master control write strobe |
| mc_wdata | input | 32 | Master control data; bit 2 is source clip, bit 3 is destination clip |
| clip_top | output | 14 | Destination top bound |
| clip_left | output | 14 | Destination left bound |
| clip_bottom | output | 14 | Destination bottom bound |
| clip_right | output | 14 | Destination right bound |
| src_clip_bottom | output | 14 | Source bottom bound |
| src_clip_right | output | 14 | Source right bound |

## Verification
The assertions assume the following about the inputs:
- Reset is high from time zero.
- The register port carries at most one access per cycle, so a read strobe never coincides with a register write.
- The master control write may coincide with a register write, and that case is covered by the reload-priority properties.

The stimulus stays within these rules. Every register task drives exactly one strobe for one cycle. Only the dedicated collision task raises the register and master control strobes together.

// File: rtl/scis_pkg.sv
package scis_pkg;
  localparam int COORD_W_DEF = 14;
  localparam int HI_LSB      = 16;
  localparam int NUM_FLD     = 8;

  // field slots in the coordinate array
  localparam int F_TOP    = 0;
  localparam int F_LEFT   = 1;
  localparam int F_BOT    = 2;
  localparam int F_RIGHT  = 3;
  localparam int F_SBOT   = 4;
  localparam int F_SRIGHT = 5;
  localparam int F_DBOT   = 6;
  localparam int F_DRIGHT = 7;

  // register word addresses
  localparam logic [7:0] A_TOP     = 8'h00;
  localparam logic [7:0] A_LEFT    = 8'h01;
  localparam logic [7:0] A_BOT     = 8'h02;
  localparam logic [7:0] A_RIGHT   = 8'h03;
  localparam logic [7:0] A_SBOT    = 8'h04;
  localparam logic [7:0] A_SRIGHT  = 8'h05;
  localparam logic [7:0] A_TL_PAIR = 8'h08;
  localparam logic [7:0] A_BR_PAIR = 8'h09;
  localparam logic [7:0] A_SBR_PAIR = 8'h0A;
  localparam logic [7:0] A_DBR_PAIR = 8'h0B;

  // master control bits
  localparam int MC_SRC_CLIP = 2;
  localparam int MC_DST_CLIP = 3;
endpackage

// File: rtl/scis_coord_reg.sv
module scis_coord_reg #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (ld_en) q <= ld_val;
    else if (wr_en) q <= wr_val;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> q == $past(ld_val)); // R10
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ld_en) |=> q == $past(wr_val)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !ld_en) |=> $stable(q)); // R8
endmodule

// File: rtl/scis_wr_decode.sv
module scis_wr_decode
  import scis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CW     = COORD_W_DEF,
  parameter int NF     = NUM_FLD
) (
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NF-1:0]        fld_we,
  output logic [NF-1:0][CW-1:0] fld_val
);
  logic [CW-1:0] lo_f, hi_f;
  logic unused_bits;

  assign lo_f = wdata[CW-1:0];
  assign hi_f = wdata[HI_LSB+CW-1:HI_LSB];
  assign unused_bits = ^{wdata[DATA_W-1:HI_LSB+CW], wdata[HI_LSB-1:CW]};

  always_comb begin
    fld_we  = '0;
    fld_val = '0;
    for (int i = 0; i < NF; i++) fld_val[i] = lo_f;
    if (we) begin
      unique case (addr)
        ADDR_W'(A_TOP):    fld_we[F_TOP]    = 1'b1;
        ADDR_W'(A_LEFT):   fld_we[F_LEFT]   = 1'b1;
        ADDR_W'(A_BOT):    fld_we[F_BOT]    = 1'b1;
        ADDR_W'(A_RIGHT):  fld_we[F_RIGHT]  = 1'b1;
        ADDR_W'(A_SBOT):   fld_we[F_SBOT]   = 1'b1;
        ADDR_W'(A_SRIGHT): fld_we[F_SRIGHT] = 1'b1;
        ADDR_W'(A_TL_PAIR): begin
          fld_we[F_LEFT] = 1'b1;
          fld_we[F_TOP]  = 1'b1;
          fld_val[F_TOP] = hi_f;
        end
        ADDR_W'(A_BR_PAIR): begin
          fld_we[F_RIGHT] = 1'b1;
          fld_we[F_BOT]   = 1'b1;
          fld_val[F_BOT]  = hi_f;
        end
        ADDR_W'(A_SBR_PAIR): begin
          fld_we[F_SRIGHT] = 1'b1;
          fld_we[F_SBOT]   = 1'b1;
          fld_val[F_SBOT]  = hi_f;
        end
        ADDR_W'(A_DBR_PAIR): begin
          fld_we[F_DRIGHT] = 1'b1;
          fld_we[F_DBOT]   = 1'b1;
          fld_val[F_DBOT]  = hi_f;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scis_rd_port.sv
module scis_rd_port
  import scis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CW     = COORD_W_DEF,
  parameter int NF     = NUM_FLD
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  re,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NF-1:0][CW-1:0] fld_q,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rd_err
);
  logic [DATA_W-1:0] rd_val;
  logic              wo_hit;

  always_comb begin
    rd_val = '0;
    wo_hit = 1'b0;
    unique case (addr)
      ADDR_W'(A_TOP):    rd_val[CW-1:0] = fld_q[F_TOP];
      ADDR_W'(A_LEFT):   rd_val[CW-1:0] = fld_q[F_LEFT];
      ADDR_W'(A_BOT):    rd_val[CW-1:0] = fld_q[F_BOT];
      ADDR_W'(A_RIGHT):  rd_val[CW-1:0] = fld_q[F_RIGHT];
      ADDR_W'(A_SBOT):   rd_val[CW-1:0] = fld_q[F_SBOT];
      ADDR_W'(A_SRIGHT): rd_val[CW-1:0] = fld_q[F_SRIGHT];
      ADDR_W'(A_DBR_PAIR): begin
        rd_val[CW-1:0]               = fld_q[F_DRIGHT];
        rd_val[HI_LSB+CW-1:HI_LSB]   = fld_q[F_DBOT];
      end
      ADDR_W'(A_TL_PAIR), ADDR_W'(A_BR_PAIR), ADDR_W'(A_SBR_PAIR):
        wo_hit = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else begin
      rd_err <= re & wo_hit;
      if (re) rdata <= rd_val;
    end
  end

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> rdata == '0); // R4
  AST_ERR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> $past(re)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R11
endmodule

// File: rtl/scissor_bank.sv
module scissor_bank
  import scis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CW     = COORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rd_err,
  input  logic              mc_we,
  input  logic [DATA_W-1:0] mc_wdata,
  output logic [CW-1:0]     clip_top,
  output logic [CW-1:0]     clip_left,
  output logic [CW-1:0]     clip_bottom,
  output logic [CW-1:0]     clip_right,
  output logic [CW-1:0]     src_clip_bottom,
  output logic [CW-1:0]     src_clip_right
);
  localparam int NF = NUM_FLD;

  logic [NF-1:0]         fld_we, fld_ld;
  logic [NF-1:0][CW-1:0] fld_wval, fld_lval, fld_q;
  logic                  src_rl, dst_rl;
  logic                  unused_mc;

  assign unused_mc = ^{mc_wdata[DATA_W-1:MC_DST_CLIP+1], mc_wdata[MC_SRC_CLIP-1:0]};
  assign src_rl = mc_we & ~mc_wdata[MC_SRC_CLIP];
  assign dst_rl = mc_we & ~mc_wdata[MC_DST_CLIP];

  scis_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW), .NF(NF)) wr_dec_i (
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .fld_we(fld_we), .fld_val(fld_wval)
  );

  // reload sources from the master control word
  always_comb begin
    fld_ld   = '0;
    fld_lval = '0;
    fld_ld[F_TOP]     = dst_rl;
    fld_ld[F_LEFT]    = dst_rl;
    fld_ld[F_BOT]     = dst_rl;
    fld_lval[F_BOT]   = fld_q[F_DBOT];
    fld_ld[F_RIGHT]   = dst_rl;
    fld_lval[F_RIGHT] = fld_q[F_DRIGHT];
    fld_ld[F_SBOT]     = src_rl;
    fld_lval[F_SBOT]   = fld_q[F_DBOT];
    fld_ld[F_SRIGHT]   = src_rl;
    fld_lval[F_SRIGHT] = fld_q[F_DRIGHT];
  end

  for (genvar g = 0; g < NF; g++) begin : g_fld
    scis_coord_reg #(.CW(CW)) reg_i (
      .clk(clk), .rst(rst),
      .wr_en(fld_we[g]), .wr_val(fld_wval[g]),
      .ld_en(fld_ld[g]), .ld_val(fld_lval[g]),
      .q(fld_q[g])
    );
  end

  scis_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW), .NF(NF)) rd_port_i (
    .clk(clk), .rst(rst), .re(reg_re), .addr(reg_addr), .fld_q(fld_q),
    .rdata(reg_rdata), .rd_err(rd_err)
  );

  assign clip_top        = fld_q[F_TOP];
  assign clip_left       = fld_q[F_LEFT];
  assign clip_bottom     = fld_q[F_BOT];
  assign clip_right      = fld_q[F_RIGHT];
  assign src_clip_bottom = fld_q[F_SBOT];
  assign src_clip_right  = fld_q[F_SRIGHT];

  AST_DST_ORIGIN_CLR: assert property (@(posedge clk) disable iff (rst)
    (mc_we && !mc_wdata[MC_DST_CLIP]) |=> (clip_top == '0 && clip_left == '0)); // R7
  AST_DST_FROM_DEF: assert property (@(posedge clk) disable iff (rst)
    (mc_we && !mc_wdata[MC_DST_CLIP]) |=>
      (clip_right == $past(fld_q[F_DRIGHT]) && clip_bottom == $past(fld_q[F_DBOT]))); // R7
  AST_SRC_FROM_DEF: assert property (@(posedge clk) disable iff (rst)
    (mc_we && !mc_wdata[MC_SRC_CLIP]) |=>
      (src_clip_right == $past(fld_q[F_DRIGHT]) && src_clip_bottom == $past(fld_q[F_DBOT]))); // R6
  AST_DST_KEEP: assert property (@(posedge clk) disable iff (rst)
    (mc_we && mc_wdata[MC_DST_CLIP] && !reg_we) |=>
      ($stable(clip_top) && $stable(clip_left) && $stable(clip_bottom) && $stable(clip_right))); // R8
  AST_SRC_KEEP: assert property (@(posedge clk) disable iff (rst)
    (mc_we && mc_wdata[MC_SRC_CLIP] && !reg_we) |=>
      ($stable(src_clip_bottom) && $stable(src_clip_right))); // R8
  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (reg_re && !reg_we && !mc_we) |=> ($stable(clip_top) && $stable(clip_right) && $stable(src_clip_right))); // R9
endmodule

// File: tb/scissor_bank_tb.sv
module scissor_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic        rd_err;
  logic        mc_we = 1'b0;
  logic [31:0] mc_wdata = '0;
  logic [13:0] clip_top, clip_left, clip_bottom, clip_right, src_clip_bottom, src_clip_right;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  // bench model of the bounds
  logic [13:0] mt = '0, ml = '0, mb = '0, mr = '0, msb = '0, msr = '0, mdb = '0, mdr = '0;

  always #4 clk = ~clk;

  scissor_bank dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .rd_err(rd_err),
    .mc_we(mc_we), .mc_wdata(mc_wdata),
    .clip_top(clip_top), .clip_left(clip_left), .clip_bottom(clip_bottom),
    .clip_right(clip_right), .src_clip_bottom(src_clip_bottom), .src_clip_right(src_clip_right)
  );

  function automatic void check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endfunction

  function automatic void model_wr(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h00: mt = d[13:0];
      8'h01: ml = d[13:0];
      8'h02: mb = d[13:0];
      8'h03: mr = d[13:0];
      8'h04: msb = d[13:0];
      8'h05: msr = d[13:0];
      8'h08: begin ml = d[13:0];  mt = d[29:16];  end
      8'h09: begin mr = d[13:0];  mb = d[29:16];  end
      8'h0A: begin msr = d[13:0]; msb = d[29:16]; end
      8'h0B: begin mdr = d[13:0]; mdb = d[29:16]; end
      default: ;
    endcase
  endfunction

  function automatic exp_t model_rd(logic [7:0] a, string req);
    exp_t e;
    e.data = '0; e.err = 1'b0; e.req = req;
    case (a)
      8'h00: e.data = {18'b0, mt};
      8'h01: e.data = {18'b0, ml};
      8'h02: e.data = {18'b0, mb};
      8'h03: e.data = {18'b0, mr};
      8'h04: e.data = {18'b0, msb};
      8'h05: e.data = {18'b0, msr};
      8'h0B: e.data = {2'b0, mdb, 2'b0, mdr};
      8'h08, 8'h09, 8'h0A: e.err = 1'b1;
      default: ;
    endcase
    return e;
  endfunction

  // driver tasks: entered and left at a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(logic [7:0] a, string req);
    exp_q.push_back(model_rd(a, req));
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic mc(bit with_reg, logic [7:0] a, logic [31:0] d, logic [31:0] m);
    logic [13:0] odb, odr;
    odb = mdb; odr = mdr;
    mc_wdata = m; mc_we = 1'b1;
    if (with_reg) begin reg_addr = a; reg_wdata = d; reg_we = 1'b1; end
    @(negedge clk);
    mc_we = 1'b0; reg_we = 1'b0;
    if (with_reg) model_wr(a, d);
    if (!m[2]) begin msr = odr; msb = odb; end
    if (!m[3]) begin mt = '0; ml = '0; mr = odr; mb = odb; end
  endtask

  task automatic chk_outs(string req);
    check({req, " top"},    {18'b0, clip_top},        {18'b0, mt});
    check({req, " left"},   {18'b0, clip_left},       {18'b0, ml});
    check({req, " bottom"}, {18'b0, clip_bottom},     {18'b0, mb});
    check({req, " right"},  {18'b0, clip_right},      {18'b0, mr});
    check({req, " sbot"},   {18'b0, src_clip_bottom}, {18'b0, msb});
    check({req, " sright"}, {18'b0, src_clip_right},  {18'b0, msr});
  endtask

  // monitor: compares read results one cycle after each read strobe
  initial begin
    forever begin
      logic had_re;
      exp_t e;
      @(posedge clk);
      had_re = reg_re;
      #1;
      if (!rst) begin
        if (had_re) begin
          if (exp_q.size() == 0) begin
            check("R11 unexpected read", 32'h1, 32'h0);
          end else begin
            e = exp_q.pop_front();
            check({e.req, " rdata"}, reg_rdata, e.data);
            check({e.req, " rd_err"}, {31'b0, rd_err}, {31'b0, e.err});
          end
        end else if (rd_err !== 1'b0) begin
          check("R4 rd_err pulse width", {31'b0, rd_err}, 32'h0);
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    check("watchdog expired", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is high
    chk_outs("R1 in reset");
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 rd_err", {31'b0, rd_err}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk_outs("R1 after reset");
    rd(8'h0B, "R1 default pair");

    // R2 individual registers, R11 back-to-back read
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, "R2 R11 top masked");
    wr(8'h01, 32'h0000_0123); rd(8'h01, "R2 left");
    wr(8'h02, 32'h0000_2AAA); rd(8'h02, "R2 bottom");
    wr(8'h03, 32'h0000_1555); rd(8'h03, "R2 right");
    wr(8'h04, 32'h0001_0042); rd(8'h04, "R2 src bottom");
    wr(8'h05, 32'h8000_3FFE); rd(8'h05, "R2 src right");
    chk_outs("R11 outputs after writes");

    // R3 pair writes
    wr(8'h08, 32'h1234_0567); chk_outs("R3 top-left pair");
    rd(8'h00, "R3 top from high half");
    rd(8'h01, "R3 left from low half");
    wr(8'h09, 32'hC0FE_4321); chk_outs("R3 bottom-right pair");
    wr(8'h0A, 32'h0777_0888); chk_outs("R3 src bottom-right pair");
    rd(8'h04, "R3 src bottom");

    // R4 write-only pairs
    rd(8'h08, "R4 top-left read");
    rd(8'h09, "R4 bottom-right read");
    rd(8'h0A, "R4 src pair read");
    rd(8'h03, "R4 err clears");

    // R5 default pair
    wr(8'h0B, 32'hC123_8456); rd(8'h0B, "R5 default readback");

    // R6 + R8: src reload, dst kept
    mc(1'b0, 8'h00, 32'h0, 32'h0000_0008); chk_outs("R6 R8 src reload dst kept");
    wr(8'h09, 32'h0100_0200); wr(8'h08, 32'h0011_0022);
    // R7 + R8: dst reload, src kept
    wr(8'h0A, 32'h0033_0044);
    mc(1'b0, 8'h00, 32'h0, 32'hFFFF_FFF4); chk_outs("R7 R8 dst reload src kept");
    rd(8'h00, "R7 top zero");
    rd(8'h02, "R7 bottom default");
    // R8 both bits set
    wr(8'h08, 32'h0005_0006); wr(8'h0A, 32'h0007_0009);
    mc(1'b0, 8'h00, 32'h0, 32'h0000_000C); chk_outs("R8 both kept");
    // both bits clear
    mc(1'b0, 8'h00, 32'h0, 32'h0000_0000); chk_outs("R6 R7 both reload");

    // R9 unmapped reads
    wr(8'h08, 32'h0010_0020);
    rd(8'h1F, "R9 unmapped");
    rd(8'h06, "R9 gap address");
    chk_outs("R9 no change");

    // R10 collisions
    mc(1'b1, 8'h00, 32'h0000_0077, 32'h0000_0004); chk_outs("R10 top write vs reload");
    mc(1'b1, 8'h0B, 32'h0AAA_0BBB, 32'h0000_0000); chk_outs("R10 old defaults used");
    rd(8'h0B, "R10 default pair updated");
    mc(1'b1, 8'h05, 32'h0000_0155, 32'h0000_0008); chk_outs("R10 src write vs reload");
    mc(1'b1, 8'h01, 32'h0000_0155, 32'h0000_0008); chk_outs("R8 dst write kept with bit set");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule